// File: doc/BRIEF.md
# PIO Timing Clock Calculator

This block turns ATA PIO timing figures, given in nanoseconds, into counts of bus clocks for the two drives that share one channel. It then packs those counts into the configuration bytes a channel timing unit expects. Software or a setup engine drives the bus frequency in MHz and, for each drive, a PIO mode number and a presence flag. It then pulses `start`. A built-in table gives the address setup, active pulse and full cycle time for modes 0 to 3. The recovery time is the cycle time less the setup and active times.

Each of the six figures (three per drive) is scaled by the bus frequency and divided by 1000 with upward rounding. One shared restoring divider does this work, one quotient bit per clock. The quotients are clamped to the ranges the timing fields can hold. The results are packed into one cycle byte per drive and one shared miscellaneous byte. The two drives share one address setup field, so that field takes the larger of the two drives' setups. A drive that is not present is given the smallest legal timing.

Top module: `pio_clk_calc`

## Requirements
- R1: Each clock count is the integer quotient (t_ns * bus_mhz + 999) / 1000, which is the time rounded up to whole clocks.
- R2: A drive's recovery count comes from the cycle time minus the setup time minus the active time, converted with the same rounding as R1.
- R3: Before packing, the address count is limited to the range 1..4, the data count to 1..16 and the recovery count to 2..17. This also applies to a bus frequency of 0.
- R4: A drive whose presence flag is 0 uses address 1, data 1 and recovery 2, whatever its mode input says. Its cycle byte is therefore 8'h00.
- R5: A cycle byte carries (data - 1) in bits 7:4 and (recovery - 2) in bits 3:0. Drive 0's byte goes to `cycle_d0` and drive 1's byte goes to `cycle_d1`.
- R6: `misc_cfg` carries (max(address_d0, address_d1) - 1) in bits 5:4 and the captured `prefetch_en` in bit 6. Bits 2:1 carry (ready delay - 2) with the ready delay fixed at 2, so those bits are 0. Bits 7, 3 and 0 are 0.
- R7: The table gives setup/active/cycle in ns as follows: mode 0 = 70/165/600, mode 1 = 50/125/383, mode 2 = 30/100/240, mode 3 = 30/80/180. Mode 3 is the highest.
- R8: `busy` is high from the cycle after an accepted `start` up to the completion cycle. `done` is high for exactly one cycle, 6*(NUM_W+2)+1 clock edges after the edge that accepted `start`, where NUM_W = 10 + MHZ_W + 1. In that same cycle the new bytes appear and `busy` is low.
- R9: All inputs are captured on the edge that accepts `start`. A `start` seen while `busy` is high is ignored, and input changes during a run do not affect its result.
- R10: After reset all three bytes, `busy` and `done` are 0. The bytes change only in a cycle where `done` is high and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calculation when idle |
| bus_mhz | input | MHZ_W | Bus clock frequency in MHz |
| mode_d0 | input | 2 | PIO mode of drive 0 |
| present_d0 | input | 1 | Drive 0 exists |
| mode_d1 | input | 2 | PIO mode of drive 1 |
| present_d1 | input | 1 | Drive 1 exists |
| prefetch_en | input | 1 | Read-prefetch enable copied to the misc byte |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion strobe |
| cycle_d0 | output | 8 | Packed data/recovery byte for drive 0 |
| cycle_d1 | output | 8 | Packed data/recovery byte for drive 1 |
| misc_cfg | output | 8 | Shared address setup, ready delay and prefetch byte |

## Verification
The bench builds the block with the default MHZ_W of 8. This lets it drive bus frequencies from 0 to 255 MHz. At 0 MHz every count falls below its lower clamp limit. At 255 MHz mode 0 pushes the address, data and recovery counts above their upper limits. Between those extremes, values such as 33, 40, 66 and 100 MHz give counts inside the ranges, where the rounding-up and the max of the two setups decide the result. With the default width the dividend is 19 bits, so a run takes 127 edges. This keeps the mid-run start and input-change cases short enough to repeat across many scenarios.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

    localparam int TIME_W    = 10;   // widest table time (600 ns) fits here
    localparam int DIVISOR   = 1000; // ns*MHz to clocks
    localparam int ROUNDUP   = DIVISOR - 1;
    localparam int MAX_MODE  = 3;
    localparam int N_DRIVES  = 2;
    localparam int N_KINDS   = 3;
    localparam int RDY_CLKS  = 2;

    localparam int ADDR_LO = 1;
    localparam int ADDR_HI = 4;
    localparam int DATA_LO = 1;
    localparam int DATA_HI = 16;
    localparam int RECV_LO = 2;
    localparam int RECV_HI = 17;

    localparam logic [1:0] K_SETUP  = 2'd0;
    localparam logic [1:0] K_ACTIVE = 2'd1;
    localparam logic [1:0] K_RECOV  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FEED,
        ST_WAIT,
        ST_PACK
    } calc_state_e;

    typedef struct packed {
        logic [TIME_W-1:0] setup;
        logic [TIME_W-1:0] active;
        logic [TIME_W-1:0] recov;
    } mode_times_t;

    function automatic mode_times_t mode_times(input logic [1:0] mode);
        int s, a, c;
        mode_times_t r;
        case (mode)
            2'd0:    begin s = 70; a = 165; c = 600; end
            2'd1:    begin s = 50; a = 125; c = 383; end
            2'd2:    begin s = 30; a = 100; c = 240; end
            default: begin s = 30; a = 80;  c = 180; end
        endcase
        r.setup  = TIME_W'(s);
        r.active = TIME_W'(a);
        r.recov  = TIME_W'(c - s - a);
        return r;
    endfunction

    function automatic int unsigned clamp_u(input int unsigned v,
                                            input int unsigned lo,
                                            input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/pio_time_select.sv
module pio_time_select
    import pio_calc_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [1:0]        kind,
    output logic [TIME_W-1:0] time_ns
);
    mode_times_t mt;

    always_comb begin
        mt = mode_times(mode);
        case (kind)
            K_SETUP:  time_ns = mt.setup;
            K_ACTIVE: time_ns = mt.active;
            default:  time_ns = mt.recov;
        endcase
    end
endmodule

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
    parameter int NUM_W = 19,
    parameter int DEN   = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    output logic [NUM_W-1:0] quot,
    output logic             valid
);
    localparam int REM_W = $clog2(DEN) + 1;
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] work_q;
    logic [REM_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [REM_W-1:0] trial;
    logic             fits;
    logic [REM_W-1:0] rem_nxt;

    always_comb begin
        trial   = {rem_q[REM_W-2:0], work_q[NUM_W-1]};
        fits    = (trial >= REM_W'(DEN));
        rem_nxt = fits ? (trial - REM_W'(DEN)) : trial;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (load) begin
                work_q <= num;
                rem_q  <= '0;
                cnt_q  <= CNT_W'(NUM_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                work_q <= {work_q[NUM_W-2:0], fits};
                rem_q  <= rem_nxt;
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    assign quot = work_q;

    // Divider only reports a result after a full run, never while loading.
    assert_valid_after_run_R1: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(run_q));
endmodule

// File: rtl/pio_cfg_pack.sv
module pio_cfg_pack
    import pio_calc_pkg::*;
#(
    parameter int NUM_W = 19
) (
    input  logic [N_DRIVES-1:0][N_KINDS-1:0][NUM_W-1:0] quot,
    input  logic [N_DRIVES-1:0]                         present,
    input  logic                                        prefetch,
    output logic [N_DRIVES-1:0][7:0]                    cycle_byte,
    output logic [7:0]                                  misc_byte
);
    int unsigned addr_clk [N_DRIVES];

    for (genvar d = 0; d < N_DRIVES; d++) begin : g_drive
        int unsigned data_clk, recv_clk;
        logic [31:0] data_m1, recv_m2;

        always_comb begin
            if (present[d]) begin
                addr_clk[d] = clamp_u(32'(quot[d][K_SETUP]),  ADDR_LO, ADDR_HI);
                data_clk    = clamp_u(32'(quot[d][K_ACTIVE]), DATA_LO, DATA_HI);
                recv_clk    = clamp_u(32'(quot[d][K_RECOV]),  RECV_LO, RECV_HI);
            end else begin
                addr_clk[d] = ADDR_LO;
                data_clk    = DATA_LO;
                recv_clk    = RECV_LO;
            end
            data_m1       = data_clk - DATA_LO;
            recv_m2       = recv_clk - RECV_LO;
            cycle_byte[d] = {data_m1[3:0], recv_m2[3:0]};
        end
    end

    logic [31:0] ax_m1;
    logic [31:0] rdy_f;

    always_comb begin
        ax_m1     = ((addr_clk[0] > addr_clk[1]) ? addr_clk[0] : addr_clk[1]) - ADDR_LO;
        rdy_f     = RDY_CLKS - 2;
        misc_byte = {1'b0, prefetch, ax_m1[1:0], 1'b0, rdy_f[1:0], 1'b0};
    end
endmodule

// File: rtl/pio_clk_calc.sv
module pio_clk_calc
    import pio_calc_pkg::*;
#(
    parameter int MHZ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MHZ_W-1:0] bus_mhz,
    input  logic [1:0]       mode_d0,
    input  logic             present_d0,
    input  logic [1:0]       mode_d1,
    input  logic             present_d1,
    input  logic             prefetch_en,
    output logic             busy,
    output logic             done,
    output logic [7:0]       cycle_d0,
    output logic [7:0]       cycle_d1,
    output logic [7:0]       misc_cfg
);
    localparam int NUM_W = TIME_W + MHZ_W + 1;

    calc_state_e                 st_q;
    logic [MHZ_W-1:0]            mhz_q;
    logic [N_DRIVES-1:0][1:0]    mode_q;
    logic [N_DRIVES-1:0]         pres_q;
    logic                        pf_q;
    logic                        drv_q;
    logic [1:0]                  kind_q;
    logic [N_DRIVES-1:0][N_KINDS-1:0][NUM_W-1:0] q_store;

    logic [TIME_W-1:0] t_ns;
    logic [NUM_W-1:0]  div_num;
    logic [NUM_W-1:0]  div_quot;
    logic              div_valid;
    logic              div_load;
    logic [N_DRIVES-1:0][7:0] pk_cycle;
    logic [7:0]        pk_misc;

    pio_time_select u_tsel (
        .mode    (mode_q[drv_q]),
        .kind    (kind_q),
        .time_ns (t_ns)
    );

    assign div_num  = {{(NUM_W-TIME_W){1'b0}}, t_ns} * {{(NUM_W-MHZ_W){1'b0}}, mhz_q}
                    + NUM_W'(ROUNDUP);
    assign div_load = (st_q == ST_FEED);

    pio_ceil_div #(.NUM_W(NUM_W), .DEN(DIVISOR)) u_div (
        .clk   (clk),
        .rst   (rst),
        .load  (div_load),
        .num   (div_num),
        .quot  (div_quot),
        .valid (div_valid)
    );

    pio_cfg_pack #(.NUM_W(NUM_W)) u_pack (
        .quot       (q_store),
        .present    (pres_q),
        .prefetch   (pf_q),
        .cycle_byte (pk_cycle),
        .misc_byte  (pk_misc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            mhz_q    <= '0;
            mode_q   <= '0;
            pres_q   <= '0;
            pf_q     <= 1'b0;
            drv_q    <= 1'b0;
            kind_q   <= K_SETUP;
            q_store  <= '0;
            done     <= 1'b0;
            cycle_d0 <= '0;
            cycle_d1 <= '0;
            misc_cfg <= '0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: if (start) begin
                    mhz_q  <= bus_mhz;
                    mode_q <= {mode_d1, mode_d0};
                    pres_q <= {present_d1, present_d0};
                    pf_q   <= prefetch_en;
                    drv_q  <= 1'b0;
                    kind_q <= K_SETUP;
                    st_q   <= ST_FEED;
                end
                ST_FEED: st_q <= ST_WAIT;
                ST_WAIT: if (div_valid) begin
                    q_store[drv_q][kind_q] <= div_quot;
                    if (drv_q && kind_q == K_RECOV) begin
                        st_q <= ST_PACK;
                    end else begin
                        if (kind_q == K_RECOV) begin
                            kind_q <= K_SETUP;
                            drv_q  <= 1'b1;
                        end else begin
                            kind_q <= kind_q + 2'd1;
                        end
                        st_q <= ST_FEED;
                    end
                end
                default: begin
                    cycle_d0 <= pk_cycle[0];
                    cycle_d1 <= pk_cycle[1];
                    misc_cfg <= pk_misc;
                    done     <= 1'b1;
                    st_q     <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy = (st_q != ST_IDLE);

    // The quotient returned by the divider is the rounded-up clock count of the current time.
    assert_quot_bounds_R1: assert property (@(posedge clk) disable iff (rst)
        div_valid |-> (64'(div_quot) * DIVISOR <= 64'(div_num)) &&
                      (64'(div_num) < (64'(div_quot) + 1) * DIVISOR));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_ends_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_inputs_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mhz_q) && $stable(mode_q) && $stable(pres_q) && $stable(pf_q));

    assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cycle_d0) && $stable(cycle_d1) && $stable(misc_cfg));
endmodule

// File: tb/test_pio_clk_calc.sv
module test_pio_clk_calc;
    localparam int MHZ_W = 8;
    localparam int NUMW  = 10 + MHZ_W + 1;
    localparam int LAT   = 6 * (NUMW + 2) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [MHZ_W-1:0] bus_mhz = '0;
    logic [1:0] mode_d0 = '0, mode_d1 = '0;
    logic present_d0 = 1'b0, present_d1 = 1'b0, prefetch_en = 1'b0;
    logic busy, done;
    logic [7:0] cycle_d0, cycle_d1, misc_cfg;

    always #4 clk = ~clk;

    pio_clk_calc #(.MHZ_W(MHZ_W)) i_pio_clk_calc (
        .clk(clk), .rst(rst), .start(start), .bus_mhz(bus_mhz),
        .mode_d0(mode_d0), .present_d0(present_d0),
        .mode_d1(mode_d1), .present_d1(present_d1),
        .prefetch_en(prefetch_en), .busy(busy), .done(done),
        .cycle_d0(cycle_d0), .cycle_d1(cycle_d1), .misc_cfg(misc_cfg)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R10";

    // reference model state
    bit m_busy = 0, m_done = 0;
    int m_cnt = 0;
    int m_c0 = 0, m_c1 = 0, m_misc = 0;
    int p_c0 = 0, p_c1 = 0, p_misc = 0;

    function automatic int tbl(int mode, int which);
        int s, a, c;
        case (mode)
            0: begin s = 70; a = 165; c = 600; end
            1: begin s = 50; a = 125; c = 383; end
            2: begin s = 30; a = 100; c = 240; end
            default: begin s = 30; a = 80; c = 180; end
        endcase
        if (which == 0) return s;
        if (which == 1) return a;
        return c;
    endfunction

    function automatic int to_clk(int t, int mhz);
        return (t * mhz + 999) / 1000;
    endfunction

    function automatic int lim(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic model_compute(input int mhz, input int m0, input bit pr0,
                                 input int m1, input bit pr1, input bit pf);
        int ad [2];
        int cy [2];
        for (int d = 0; d < 2; d++) begin
            int m = (d == 0) ? m0 : m1;
            bit pr = (d == 0) ? pr0 : pr1;
            int s = tbl(m, 0), a = tbl(m, 1), c = tbl(m, 2);
            int dt, rc;
            if (pr) begin
                ad[d] = lim(to_clk(s, mhz), 1, 4);
                dt    = lim(to_clk(a, mhz), 1, 16);
                rc    = lim(to_clk(c - s - a, mhz), 2, 17);
            end else begin
                ad[d] = 1; dt = 1; rc = 2;
            end
            cy[d] = ((dt - 1) << 4) | (rc - 2);
        end
        p_c0 = cy[0];
        p_c1 = cy[1];
        p_misc = (int'(pf) << 6) | ((((ad[0] > ad[1]) ? ad[0] : ad[1]) - 1) << 4) | ((2 - 2) << 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            m_c0 = 0; m_c1 = 0; m_misc = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1;
                    m_c0 = p_c0; m_c1 = p_c1; m_misc = p_misc;
                end
            end else if (start) begin
                model_compute(int'(bus_mhz), int'(mode_d0), present_d0,
                              int'(mode_d1), present_d1, prefetch_en);
                m_busy = 1; m_cnt = LAT;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (busy !== m_busy || done !== m_done) begin
                errors++;
                $display("FAIL R8: busy/done actual %b/%b expected %b/%b at cycle %0d",
                         busy, done, m_busy, m_done, cycles);
            end
            checks++;
            if (cycle_d0 !== 8'(m_c0) || cycle_d1 !== 8'(m_c1) || misc_cfg !== 8'(m_misc)) begin
                errors++;
                $display("FAIL %s R5 R6: bytes actual %h %h %h expected %h %h %h at cycle %0d",
                         tag, cycle_d0, cycle_d1, misc_cfg,
                         8'(m_c0), 8'(m_c1), 8'(m_misc), cycles);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles %0d expected under 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic launch(input int mhz, input int m0, input bit p0,
                          input int m1, input bit p1, input bit pf);
        @(negedge clk);
        bus_mhz = MHZ_W'(mhz);
        mode_d0 = 2'(m0); present_d0 = p0;
        mode_d1 = 2'(m1); present_d1 = p1;
        prefetch_en = pf;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run();
        while (m_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic run(input string t, input int mhz, input int m0, input bit p0,
                       input int m1, input bit p1, input bit pf);
        tag = t;
        launch(mhz, m0, p0, m1, p1, pf);
        finish_run();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || cycle_d0 !== 8'h00 || cycle_d1 !== 8'h00 || misc_cfg !== 8'h00) begin
            errors++;
            $display("FAIL R10: reset state actual %b %b %h %h %h expected 0 0 00 00 00",
                     busy, done, cycle_d0, cycle_d1, misc_cfg);
        end

        run("R1 R7", 33, 0, 1, 3, 1, 1);
        run("R1 R7", 50, 1, 1, 2, 1, 0);
        run("R2", 100, 1, 1, 1, 1, 1);
        run("R4", 66, 2, 1, 0, 0, 0);
        run("R4", 200, 3, 0, 0, 0, 1);
        run("R3", 255, 0, 1, 0, 1, 1);
        run("R3", 0, 3, 1, 2, 1, 0);
        run("R6", 40, 3, 1, 1, 1, 0);
        run("R6", 150, 2, 1, 0, 1, 1);
        run("R7", 120, 3, 1, 3, 1, 0);

        // R9: start and input changes during a run are ignored
        tag = "R9";
        launch(80, 0, 1, 2, 1, 1);
        repeat (20) @(negedge clk);
        bus_mhz = 8'd5; mode_d0 = 2'd3; present_d0 = 1'b0; prefetch_en = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_run();

        // R10: outputs hold while inputs move without a start
        tag = "R10";
        bus_mhz = 8'd250; mode_d0 = 2'd0; present_d0 = 1'b1;
        mode_d1 = 2'd1; present_d1 = 1'b1; prefetch_en = 1'b1;
        repeat (40) @(negedge clk);

        // R8: back-to-back starts, one held high across the completion cycle
        tag = "R8";
        launch(90, 1, 1, 3, 1, 0);
        start = 1'b1;
        while (m_busy) @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        finish_run();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule